// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller Pair

This block serves sixteen interrupt lines with two eight-pin priority controllers, one acting as primary and one as secondary. Line n belongs to controller n/8, pin n mod 8. Each controller keeps a request register, an in-service register, a rotating priority pointer and a "raised" flag. When the secondary controller has an eligible request, it signals the primary through a one-cycle event on primary pin 2. When the primary has an eligible request, it drives a single interrupt output toward the processor.

The processor reads the vector of the pending interrupt from a combinational output. It then returns that vector on an acknowledge port, and the acknowledged pin moves into service. Command decoding on the processor side is not part of this block. The masks, vector bases, automatic end-of-interrupt selects, rotation selects and the nested-cascade select all arrive as plain inputs. Only the edge/level trigger selection is held in the block, as two 8-bit registers written through a small write port.

Top module: `irq_pair_ctrl`

## Requirements
- R1: A request bit is set on the clock edge at which its line is sampled high after being sampled low. A later fall of an edge-triggered line leaves the latched request set.
- R2: A line whose trigger bit is 1 (level) sets its request bit on every edge at which it is sampled high. An acknowledge therefore leaves that request set while the line stays high.
- R3: A trigger write with `elc_sel`=0 loads `elc_m` with `elc_wdata & 8'hF8`, and with `elc_sel`=1 loads `elc_s` with `elc_wdata & 8'hDE`. Lines 0, 1, 2, 8 and 13 therefore stay edge triggered.
- R4: When the secondary has an eligible request and its raised flag is clear, it sets the flag and sets primary request bit 2 on the same edge. It signals once until it is acknowledged.
- R5: When the primary has an eligible request and its raised flag is clear, `cpu_int` goes to 1 on the next edge. It stays at 1 until an acknowledge.
- R6: Pins are ranked from pointer+1 upward, wrapping modulo 8, and the pointer resets to 7. An eligible pin is requested, unmasked (mask bit 1 blocks), and ranked above every in-service pin. With `nest_m`=1, primary in-service bit 2 does not block.
- R7: `vector` = {base, pin}, with the base in bits 7:3. If the primary winner is pin 2, the secondary base and the secondary winner are used.
- R8: If the selected controller has no eligible pin, pin 7 is reported, giving the spurious vector.
- R9: An acknowledge whose bits 7:3 equal `base_s` accepts pin `ack_vector[2:0]` on the secondary and also accepts pin 2 on the primary. Any other acknowledge accepts pin `ack_vector[2:0]` on the primary.
- R10: Accepting a pin does the following:
  - it clears the controller's raised flag;
  - it clears the request bit if the line is low;
  - it sets the in-service bit when automatic end-of-interrupt is 0;
  - when automatic end-of-interrupt and rotation are both 1, it moves the pointer to that pin instead.
- R11: In the acknowledge cycle `cpu_int` drops. Both controllers are evaluated again on the following edge, so a remaining request raises `cpu_int` one cycle later.
- R12: After reset, all requests, in-service bits, raised flags and trigger registers are 0, and the vector is {base_m, 7}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Interrupt lines; bit n is line n |
| mask_m | input | 8 | Primary pin masks, 1 blocks |
| mask_s | input | 8 | Secondary pin masks, 1 blocks |
| base_m | input | 5 | Primary vector base, bits 7:3 of its vectors |
| base_s | input | 5 | Secondary vector base |
| aeoi_m | input | 1 | Primary automatic end-of-interrupt |
| aeoi_s | input | 1 | Secondary automatic end-of-interrupt |
| rotate_m | input | 1 | Primary rotation on acceptance |
| rotate_s | input | 1 | Secondary rotation on acceptance |
| nest_m | input | 1 | Primary pin 2 in service does not block |
| elc_wr | input | 1 | Trigger register write strobe |
| elc_sel | input | 1 | 0 selects primary, 1 secondary |
| elc_wdata | input | 8 | Trigger write data, 1 = level |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_vector | input | 8 | Acknowledged vector |
| cpu_int | output | 1 | Interrupt toward the processor |
| vector | output | 8 | Vector of the pending interrupt |
| elc_m | output | 8 | Primary trigger register |
| elc_s | output | 8 | Secondary trigger register |
| req_m | output | 8 | Primary request register |
| req_s | output | 8 | Secondary request register |
| isr_m | output | 8 | Primary in-service register |
| isr_s | output | 8 | Secondary in-service register |

## Verification
An acknowledge of a primary pin can arrive in the same cycle as a new edge on a secondary line. The primary then clears its raised flag while the cascade event that follows is still on its way. The bench provokes this by driving the acknowledge and the rising secondary line together, once directed and also at random. It then requires the output to rise again with the secondary's vector, and compares every register against a transaction-level model that applies the edge before the acceptance.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  localparam int PINS     = 8;
  localparam int PIN_W    = $clog2(PINS);
  localparam int VEC_W    = 8;
  localparam int BASE_W   = VEC_W - PIN_W;
  localparam int LINES    = 2 * PINS;
  localparam int CASC_PIN = 2;
  localparam logic [PINS-1:0]  ELC_KEEP_M = 8'hF8;
  localparam logic [PINS-1:0]  ELC_KEEP_S = 8'hDE;
  localparam logic [PIN_W-1:0] IDLE_PIN   = PIN_W'(PINS - 1);

  typedef struct packed {
    logic             hit;
    logic [PIN_W-1:0] pin;
  } pick_t;

  // Walk pins from low_ptr+1 upward; stop at the first in-service pin.
  function automatic pick_t pick_winner(input logic [PINS-1:0] req,
                                        input logic [PINS-1:0] isr,
                                        input logic [PINS-1:0] msk,
                                        input logic [PIN_W-1:0] low_ptr,
                                        input logic nest);
    pick_t            r;
    logic [PINS-1:0]  blk;
    logic             stop;
    logic [PIN_W-1:0] p;
    r    = '0;
    stop = 1'b0;
    blk  = isr;
    if (nest) blk[CASC_PIN] = 1'b0;
    for (int i = 1; i <= PINS; i++) begin
      p = low_ptr + PIN_W'(i);
      if (!stop) begin
        if (blk[p]) begin
          stop = 1'b1;
        end else if (req[p] && !msk[p]) begin
          r.hit = 1'b1;
          r.pin = p;
          stop  = 1'b1;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] make_vec(input logic [BASE_W-1:0] base,
                                                input logic [PIN_W-1:0] pin);
    return {base, pin};
  endfunction
endpackage

// File: rtl/irqp_trig.sv
module irqp_trig
  import irqp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines_i,
  input  logic [LINES-1:0] level_i,
  output logic [LINES-1:0] set_o
);
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lines_i;
  end

  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign set_o[k] = lines_i[k] & (~prev_q[k] | level_i[k]);
  end
endmodule

// File: rtl/irqp_elc.sv
module irqp_elc
  import irqp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic            sel_i,
  input  logic [PINS-1:0] wdata_i,
  output logic [PINS-1:0] elc_m_o,
  output logic [PINS-1:0] elc_s_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elc_m_o <= '0;
      elc_s_o <= '0;
    end else if (wr_i) begin
      if (sel_i) elc_s_o <= wdata_i & ELC_KEEP_S;
      else       elc_m_o <= wdata_i & ELC_KEEP_M;
    end
  end
endmodule

// File: rtl/irqp_unit.sv
module irqp_unit
  import irqp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PINS-1:0]  set_i,
  input  logic [PINS-1:0]  line_i,
  input  logic [PINS-1:0]  mask_i,
  input  logic             aeoi_i,
  input  logic             rotate_i,
  input  logic             nest_i,
  input  logic             acc_i,
  input  logic [PIN_W-1:0] acc_pin_i,
  output logic [PINS-1:0]  req_o,
  output logic [PINS-1:0]  isr_o,
  output logic             raised_o,
  output pick_t            win_o,
  output logic             fire_o
);
  logic [PINS-1:0]  req_q, isr_q, acc_bit;
  logic [PIN_W-1:0] ptr_q;
  logic             raised_q;

  assign win_o    = pick_winner(req_q, isr_q, mask_i, ptr_q, nest_i);
  assign fire_o   = win_o.hit && !raised_q && !acc_i;
  assign acc_bit  = acc_i ? (PINS'(1) << acc_pin_i) : '0;
  assign req_o    = req_q;
  assign isr_o    = isr_q;
  assign raised_o = raised_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= '0;
      isr_q    <= '0;
      ptr_q    <= IDLE_PIN;
      raised_q <= 1'b0;
    end else begin
      req_q <= (req_q & ~(acc_bit & ~line_i)) | set_i;
      if (acc_i && !aeoi_i)             isr_q <= isr_q | acc_bit;
      if (acc_i && aeoi_i && rotate_i)  ptr_q <= acc_pin_i;
      if (acc_i)       raised_q <= 1'b0;
      else if (fire_o) raised_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_pair_ctrl.sv
module irq_pair_ctrl
  import irqp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_in,
  input  logic [PINS-1:0]   mask_m,
  input  logic [PINS-1:0]   mask_s,
  input  logic [BASE_W-1:0] base_m,
  input  logic [BASE_W-1:0] base_s,
  input  logic              aeoi_m,
  input  logic              aeoi_s,
  input  logic              rotate_m,
  input  logic              rotate_s,
  input  logic              nest_m,
  input  logic              elc_wr,
  input  logic              elc_sel,
  input  logic [PINS-1:0]   elc_wdata,
  input  logic              ack_valid,
  input  logic [VEC_W-1:0]  ack_vector,
  output logic              cpu_int,
  output logic [VEC_W-1:0]  vector,
  output logic [PINS-1:0]   elc_m,
  output logic [PINS-1:0]   elc_s,
  output logic [PINS-1:0]   req_m,
  output logic [PINS-1:0]   req_s,
  output logic [PINS-1:0]   isr_m,
  output logic [PINS-1:0]   isr_s
);
  logic [LINES-1:0] set_all;
  logic [PINS-1:0]  m_set;
  logic             slave_hit, acc_s;
  logic [PIN_W-1:0] acc_m_pin;
  logic             s_fire, m_fire, s_raised, m_raised, m_hit;
  pick_t            s_win, m_win;

  irqp_elc u_elc (
    .clk(clk), .rst_n(rst_n), .wr_i(elc_wr), .sel_i(elc_sel),
    .wdata_i(elc_wdata), .elc_m_o(elc_m), .elc_s_o(elc_s)
  );

  irqp_trig u_trig (
    .clk(clk), .rst_n(rst_n), .lines_i(irq_in),
    .level_i({elc_s, elc_m}), .set_o(set_all)
  );

  assign slave_hit = (ack_vector[VEC_W-1:PIN_W] == base_s);
  assign acc_s     = ack_valid && slave_hit;
  assign acc_m_pin = slave_hit ? PIN_W'(CASC_PIN) : ack_vector[PIN_W-1:0];
  assign m_set     = set_all[PINS-1:0] | (PINS'(s_fire) << CASC_PIN);

  irqp_unit u_sec (
    .clk(clk), .rst_n(rst_n), .set_i(set_all[LINES-1:PINS]),
    .line_i(irq_in[LINES-1:PINS]), .mask_i(mask_s), .aeoi_i(aeoi_s),
    .rotate_i(rotate_s), .nest_i(1'b0), .acc_i(acc_s),
    .acc_pin_i(ack_vector[PIN_W-1:0]), .req_o(req_s), .isr_o(isr_s),
    .raised_o(s_raised), .win_o(s_win), .fire_o(s_fire)
  );

  irqp_unit u_pri (
    .clk(clk), .rst_n(rst_n), .set_i(m_set),
    .line_i(irq_in[PINS-1:0]), .mask_i(mask_m), .aeoi_i(aeoi_m),
    .rotate_i(rotate_m), .nest_i(nest_m), .acc_i(ack_valid),
    .acc_pin_i(acc_m_pin), .req_o(req_m), .isr_o(isr_m),
    .raised_o(m_raised), .win_o(m_win), .fire_o(m_fire)
  );

  assign m_hit   = m_win.hit;
  assign cpu_int = m_raised;

  always_comb begin
    if (m_win.hit && m_win.pin == PIN_W'(CASC_PIN))
      vector = make_vec(base_s, s_win.hit ? s_win.pin : IDLE_PIN);
    else
      vector = make_vec(base_m, m_win.hit ? m_win.pin : IDLE_PIN);
  end
endmodule

// File: rtl/irqp_chk.sv
module irqp_chk
  import irqp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] irq_in,
  input logic             ack_valid,
  input logic             cpu_int,
  input logic             s_fire,
  input logic             s_raised,
  input logic             m_fire,
  input logic             m_hit,
  input logic [PINS-1:0]  req_m,
  input logic [PINS-1:0]  req_s
);
  logic [LINES-1:0] req_all;
  assign req_all = {req_s, req_m};

  // R5
  int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int && !ack_valid |=> cpu_int);

  // R5
  int_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_int) |-> $past(m_hit) && $past(m_fire));

  // R11
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> !cpu_int);

  // R4
  casc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_fire |=> req_m[CASC_PIN]);

  // R4
  casc_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_fire |=> s_raised && !s_fire);

  for (genvar k = 0; k < LINES; k++) begin : g_edge
    // R1
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_in[k]) |=> req_all[k]);
  end
endmodule

bind irq_pair_ctrl irqp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_valid(ack_valid),
  .cpu_int(cpu_int), .s_fire(s_fire), .s_raised(s_raised),
  .m_fire(m_fire), .m_hit(m_hit), .req_m(req_m), .req_s(req_s)
);

// File: tb/sim_irq_pair_ctrl.sv
module sim_irq_pair_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic [15:0] irq_in;
  logic [7:0]  mask_m, mask_s, elc_wdata, ack_vector;
  logic [4:0]  base_m, base_s;
  logic        aeoi_m, aeoi_s, rotate_m, rotate_s, nest_m, elc_wr, elc_sel, ack_valid;
  logic        cpu_int;
  logic [7:0]  vector, elc_m, elc_s, req_m, req_s, isr_m, isr_s;

  irq_pair_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_m(mask_m), .mask_s(mask_s),
    .base_m(base_m), .base_s(base_s), .aeoi_m(aeoi_m), .aeoi_s(aeoi_s),
    .rotate_m(rotate_m), .rotate_s(rotate_s), .nest_m(nest_m),
    .elc_wr(elc_wr), .elc_sel(elc_sel), .elc_wdata(elc_wdata),
    .ack_valid(ack_valid), .ack_vector(ack_vector), .cpu_int(cpu_int),
    .vector(vector), .elc_m(elc_m), .elc_s(elc_s), .req_m(req_m),
    .req_s(req_s), .isr_m(isr_m), .isr_s(isr_s)
  );

  int n_chk = 0, n_fail = 0;

  // transaction-level model
  logic [7:0]  mreq [2];
  logic [7:0]  misr [2];
  logic [7:0]  melc [2];
  bit          mraised [2];
  logic [2:0]  mptr [2];
  logic [15:0] mlines;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int mwin(input int c);
    logic [7:0] blk, mk;
    int p;
    mk  = (c == 1) ? mask_s : mask_m;
    blk = misr[c];
    if (c == 0 && nest_m) blk[2] = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      p = (int'(mptr[c]) + k) % 8;
      if (blk[p]) return -1;
      if (mreq[c][p] && !mk[p]) return p;
    end
    return -1;
  endfunction

  function automatic logic [7:0] mvec();
    int wm, ws;
    wm = mwin(0);
    if (wm == 2) begin
      ws = mwin(1);
      return {base_s, (ws < 0) ? 3'd7 : 3'(ws)};
    end
    return {base_m, (wm < 0) ? 3'd7 : 3'(wm)};
  endfunction

  task automatic m_reset();
    for (int c = 0; c < 2; c++) begin
      mreq[c] = 0; misr[c] = 0; melc[c] = 0; mraised[c] = 0; mptr[c] = 3'd7;
    end
    mlines = 0;
  endtask

  task automatic m_settle();
    mreq[0] |= mlines[7:0] & melc[0];
    mreq[1] |= mlines[15:8] & melc[1];
    if (!mraised[1] && mwin(1) >= 0) begin
      mraised[1] = 1; mreq[0][2] = 1'b1;
    end
    if (!mraised[0] && mwin(0) >= 0) mraised[0] = 1;
  endtask

  task automatic m_accept(input int c, input int pin);
    bit ae, ro;
    ae = (c == 1) ? aeoi_s : aeoi_m;
    ro = (c == 1) ? rotate_s : rotate_m;
    mraised[c] = 0;
    if (!mlines[c*8+pin]) mreq[c][pin] = 1'b0;
    if (ae) begin
      if (ro) mptr[c] = 3'(pin);
    end else begin
      misr[c][pin] = 1'b1;
    end
  endtask

  task automatic m_event(input bit a, input logic [7:0] v, input logic [15:0] nl);
    logic [15:0] rise;
    rise   = nl & ~mlines;
    mlines = nl;
    mreq[0] |= rise[7:0];
    mreq[1] |= rise[15:8];
    if (a) begin
      if (v[7:3] == base_s) begin
        m_accept(1, int'(v[2:0])); m_accept(0, 2);
      end else begin
        m_accept(0, int'(v[2:0]));
      end
    end
    m_settle();
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_event(input bit a, input logic [7:0] v, input logic [15:0] nl);
    irq_in = nl; ack_valid = a; ack_vector = v;
    tick();
    ack_valid = 0;
    repeat (6) tick();
    m_event(a, v, nl);
  endtask

  task automatic do_reset();
    rst_n = 0; irq_in = 0; ack_valid = 0; elc_wr = 0;
    repeat (2) tick();
    rst_n = 1;
    tick();
    m_reset();
  endtask

  task automatic do_elc(input bit sel, input logic [7:0] d);
    elc_wr = 1; elc_sel = sel; elc_wdata = d;
    tick();
    elc_wr = 0;
    repeat (4) tick();
    melc[sel] = d & (sel ? 8'hDE : 8'hF8);
    m_settle();
  endtask

  task automatic do_cfg();
    repeat (4) tick();
    m_settle();
  endtask

  task automatic check_all();
    chk("R5 cpu_int", cpu_int, mraised[0]);
    chk("R6 R7 vector", vector, mvec());
    chk("R1 R4 req_m", req_m, mreq[0]);
    chk("R1 R9 req_s", req_s, mreq[1]);
    chk("R10 isr_m", isr_m, misr[0]);
    chk("R10 isr_s", isr_s, misr[1]);
    chk("R3 elc_m", elc_m, melc[0]);
    chk("R3 elc_s", elc_s, melc[1]);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [15:0] nl;
    int r;
    void'($urandom(32'd6151));
    base_m = 5'h01; base_s = 5'h0E; mask_m = 0; mask_s = 0;
    aeoi_m = 1; aeoi_s = 1; rotate_m = 0; rotate_s = 0; nest_m = 0;
    elc_sel = 0; elc_wdata = 0; ack_vector = 0;
    do_reset();
    check_all();
    chk("R12 cpu_int after reset", cpu_int, 0);
    chk("R8 R12 vector after reset", vector, 8'h0F);

    do_elc(0, 8'hFF); chk("R3 master mask", elc_m, 8'hF8);
    do_elc(1, 8'hFF); chk("R3 slave mask", elc_s, 8'hDE);
    do_elc(0, 8'h00); do_elc(1, 8'h00);

    // edges on pins 3 and 5, then fall: requests stay
    do_event(0, 0, 16'h0028); do_event(0, 0, 16'h0000);
    chk("R1 falling keeps request", req_m, 8'h28);
    chk("R7 vector pin3", vector, 8'h0B);
    ack_valid = 1; ack_vector = 8'h0B;
    tick();
    ack_valid = 0;
    chk("R11 int drops on ack", cpu_int, 0);
    tick();
    chk("R11 int re-raised", cpu_int, 1);
    chk("R11 next vector", vector, 8'h0D);
    repeat (4) tick();
    m_event(1, 8'h0B, 16'h0000); check_all();
    do_event(1, 8'h0D, 0); check_all();
    chk("R8 spurious vector", vector, 8'h0F);

    // level line 3
    do_elc(0, 8'h08);
    do_event(0, 0, 16'h0008);
    do_event(1, 8'h0B, 16'h0008);
    chk("R2 level re-latch", req_m[3], 1);
    chk("R2 level re-raise", cpu_int, 1);
    do_event(0, 0, 0); do_event(1, 8'h0B, 0); check_all();
    do_elc(0, 8'h00);

    // cascade through line 9
    do_event(0, 0, 16'h0200); do_event(0, 0, 0);
    chk("R4 cascade sets pin2", req_m[2], 1);
    chk("R7 slave vector", vector, 8'h71);
    do_event(1, 8'h71, 0);
    chk("R9 slave ack clears", {req_s[1], req_m[2], cpu_int}, 0);
    check_all();

    // ack of master pin 4 together with a new edge on line 11
    do_event(0, 0, 16'h0010); do_event(0, 0, 0);
    do_event(1, 8'h0C, 16'h0800);
    chk("R11 R9 concurrent int", cpu_int, 1);
    chk("R11 R9 concurrent vector", vector, 8'h73);
    check_all();
    do_event(0, 0, 0); do_event(1, 8'h73, 0); check_all();

    // nested cascade
    aeoi_m = 0; aeoi_s = 0; do_cfg();
    do_event(0, 0, 16'h0200); do_event(0, 0, 0); do_event(1, 8'h71, 0);
    do_event(0, 0, 16'h0100); do_event(0, 0, 0);
    chk("R6 pin2 in service blocks", cpu_int, 0);
    nest_m = 1; do_cfg();
    chk("R6 nested unblocks", cpu_int, 1);
    chk("R6 nested vector", vector, 8'h70);
    check_all();
    nest_m = 0; aeoi_m = 1; aeoi_s = 1; rotate_m = 1;
    do_reset();

    // rotation
    do_event(0, 0, 16'h000B); do_event(0, 0, 0);
    chk("R6 default order", vector, 8'h08);
    do_event(1, 8'h08, 0); do_event(1, 8'h09, 0);
    do_event(0, 0, 16'h0001); do_event(0, 0, 0);
    chk("R10 rotate order", vector, 8'h0B);
    check_all();
    rotate_m = 0;

    for (int e = 0; e < 30; e++) begin
      do_reset();
      base_m = 5'($urandom);
      do base_s = 5'($urandom); while (base_s == base_m);
      mask_m = 8'($urandom & $urandom); mask_s = 8'($urandom & $urandom);
      aeoi_m = ($urandom % 4) != 0; aeoi_s = ($urandom % 4) != 0;
      rotate_m = 1'($urandom); rotate_s = 1'($urandom); nest_m = 1'($urandom);
      do_cfg();
      do_elc(0, 8'($urandom)); do_elc(1, 8'($urandom));
      check_all();
      for (int t = 0; t < 14; t++) begin
        r = int'($urandom % 10);
        v = mvec();
        if ($urandom % 4 == 0) v = ($urandom % 2) ? {base_s, 3'($urandom)} : 8'($urandom);
        nl = (mlines ^ 16'($urandom & $urandom)) & 16'hFFFB;
        if (r == 0) begin
          mask_m = 8'($urandom & $urandom); mask_s = 8'($urandom & $urandom); do_cfg();
        end else if (r == 1) do_elc(1'($urandom), 8'($urandom));
        else if (r < 6) do_event(0, 0, nl);
        else if (r < 9) do_event(1, v, mlines);
        else do_event(1, v, nl);
        check_all();
      end
    end
    summary();
    $finish;
  end
endmodule